// File: doc/BRIEF.md
# Programmable Stage-Select Binary Timer

This block is a clocked 24-stage binary divider with a selectable output tap. Every clock cycle on which the hold input is low advances the chain by one count. Software or a parent block picks one of the upper sixteen stages with a 4-bit code, and that stage drives the single output. This gives a programmable divide ratio from 2^9 to 2^24 of the clock-enable rate.

Synchronous clear and fill inputs load the whole chain with a known state. A skip input freezes the lowest eight stages, so the upper sixteen count straight from the clock. When skip, fill and clear are all high together, the chain splits into three 8-stage sections that count in parallel. This lets every stage be exercised in a few hundred cycles. An optional one-shot turns each rising edge of the chosen tap into a pulse whose length is a programmable number of clocks.

Top module: `prog_tap_timer`

## Requirements
- R1: While `rst_n` is low, every stage and the one-shot are cleared and `tap_out` reads 0. The internal release of reset follows `rst_n` rising after two clock edges.
- R2: When no force input is high and `hold` is 0, the 24-stage value (stage k is bit k-1) goes up by one per clock and wraps from all ones to all zeros.
- R3: Outside the split mode, `force_zero` clears every stage on the next clock, whatever `hold` and `force_ones` are.
- R4: When `force_ones` is high and `force_zero` is low, every stage is set to 1 on the next clock, whatever `hold` is.
- R5: When `hold` is 1 and neither force input is high, no stage changes.
- R6: When `skip_low` is 1 and neither force input is high, stages 1 to 8 keep their value. Stages 9 to 24 count as a 16-bit value that goes up by one per clock with `hold` low.
- R7: `tap_sel` (bit 0 is the LSB) selects stage 9 + `tap_sel`. So 0 gives stage 9 and 15 gives stage 24, and the same mapping holds with `skip_low` set.
- R8: When `skip_low`, `force_ones` and `force_zero` are all 1, stages 1–8, 9–16 and 17–24 each go up by one per unheld clock. Each wraps within its own eight bits, and no carry passes between sections.
- R9: With `oneshot_en` at 0, `tap_out` equals the selected stage in the same cycle that stage takes its value.
- R10: With `oneshot_en` at 1, a rising edge of the selected stage makes `tap_out` high from the next clock for exactly `pulse_width` clocks. A width of 0 acts as 1.
- R11: A new rising edge of the selected stage while the pulse is running restarts the full width count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Stops counting while 1 |
| skip_low | input | 1 | Freezes stages 1–8; with both force inputs, selects the split mode |
| force_ones | input | 1 | Synchronous set of all stages |
| force_zero | input | 1 | Synchronous clear of all stages |
| tap_sel | input | 4 | Selects stage 9 + code as the tap |
| oneshot_en | input | 1 | 1 routes the tap through the one-shot |
| pulse_width | input | 8 | One-shot length in clocks (0 treated as 1) |
| tap_out | output | 1 | Selected stage or one-shot pulse |

## Verification
A wrong count in the low eight stages stays hidden until the next carry into stage 9. That can take up to 256 enabled cycles, so the bench preloads the low byte and then runs past the carry cycle by cycle. An error in the upper stages shows on the very next cycle, because the tap select is swept across all sixteen codes. In the split mode, a stray carry between sections flips a tap bit within a single section period. A wrong one-shot count shows as an output edge one cycle early or late.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_CLEAR = 2'd2,
    MODE_FILL  = 2'd3
  } chain_mode_e;

  // Priority: split mode, then clear, then fill, then ordinary running.
  function automatic chain_mode_e decode_mode(input logic skip, input logic ones,
                                              input logic zero);
    if (skip && ones && zero) return MODE_SPLIT;
    if (zero)                 return MODE_CLEAR;
    if (ones)                 return MODE_FILL;
    return MODE_RUN;
  endfunction

endpackage

// File: rtl/ptt_chain.sv
module ptt_chain
  import ptt_pkg::*;
#(
  parameter int STAGES  = 24,
  parameter int SECTION = 8,
  parameter int SKIP    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chain_mode_e       mode,
  input  logic              adv,
  input  logic              skip,
  output logic [STAGES-1:0] stage_q
);

  localparam int NSEC = STAGES / SECTION;
  localparam int HI_W = STAGES - SKIP;

  logic [STAGES-1:0] stage_d;
  logic [STAGES-1:0] sec_inc;
  logic [STAGES-1:0] full_inc;
  logic [STAGES-1:0] hi_inc;

  // Each section increments on its own, with no carry between sections.
  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    assign sec_inc[g*SECTION +: SECTION] =
      stage_q[g*SECTION +: SECTION] + SECTION'(1);
  end

  assign full_inc = stage_q + STAGES'(1);
  assign hi_inc   = {stage_q[STAGES-1:SKIP] + HI_W'(1), stage_q[SKIP-1:0]};

  always_comb begin
    stage_d = stage_q;
    unique case (mode)
      MODE_CLEAR: stage_d = '0;
      MODE_FILL:  stage_d = '1;
      MODE_SPLIT: if (adv) stage_d = sec_inc;
      MODE_RUN:   if (adv) stage_d = skip ? hi_inc : full_inc;
      default:    stage_d = stage_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

endmodule

// File: rtl/ptt_tap_mux.sv
module ptt_tap_mux #(
  parameter int SEL_W = 4
) (
  input  logic [(1<<SEL_W)-1:0] taps,
  input  logic [SEL_W-1:0]      sel,
  output logic                  tap_bit
);

  assign tap_bit = taps[sel];

endmodule

// File: rtl/ptt_oneshot.sv
module ptt_oneshot #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic [PW_W-1:0] width,
  output logic            active
);

  logic            trig_prev_q;
  logic [PW_W-1:0] left_q;
  logic [PW_W-1:0] left_d;
  logic            rise;

  assign rise = trig && !trig_prev_q;

  always_comb begin
    left_d = left_q;
    if (rise)              left_d = (width == '0) ? PW_W'(1) : width;
    else if (left_q != '0) left_d = left_q - PW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_prev_q <= 1'b0;
      left_q      <= '0;
    end else begin
      trig_prev_q <= trig;
      left_q      <= left_d;
    end
  end

  assign active = (left_q != '0);

endmodule

// File: rtl/prog_tap_timer.sv
module prog_tap_timer
  import ptt_pkg::*;
#(
  parameter int STAGES  = 24,
  parameter int SECTION = 8,
  parameter int SKIP    = 8,
  parameter int SEL_W   = 4,
  parameter int PW_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             skip_low,
  input  logic             force_ones,
  input  logic             force_zero,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             oneshot_en,
  input  logic [PW_W-1:0]  pulse_width,
  output logic             tap_out
);

  localparam int BASE = STAGES - (1 << SEL_W);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  chain_mode_e       mode;
  logic [STAGES-1:0] stage_q;
  logic              tap_bit;
  logic              pulse;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode = decode_mode(skip_low, force_ones, force_zero);

  ptt_chain #(
    .STAGES (STAGES),
    .SECTION(SECTION),
    .SKIP   (SKIP)
  ) chain_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .mode   (mode),
    .adv    (!hold),
    .skip   (skip_low),
    .stage_q(stage_q)
  );

  ptt_tap_mux #(
    .SEL_W(SEL_W)
  ) mux_i (
    .taps   (stage_q[STAGES-1:BASE]),
    .sel    (tap_sel),
    .tap_bit(tap_bit)
  );

  ptt_oneshot #(
    .PW_W(PW_W)
  ) shot_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .trig  (tap_bit),
    .width (pulse_width),
    .active(pulse)
  );

  assign tap_out = oneshot_en ? pulse : tap_bit;

endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int STAGES  = 24,
  parameter int SECTION = 8,
  parameter int SKIP    = 8,
  parameter int SEL_W   = 4
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              hold,
  input logic              skip_low,
  input logic              force_ones,
  input logic              force_zero,
  input logic [SEL_W-1:0]  tap_sel,
  input logic              oneshot_en,
  input logic [STAGES-1:0] stage_q,
  input logic              tap_bit,
  input logic              tap_out
);

  localparam int BASE = STAGES - (1 << SEL_W);

  logic split;
  assign split = skip_low && force_ones && force_zero;

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (force_zero && !split) |=> (stage_q == '0));

  a_r4_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    (force_ones && !force_zero) |=> (stage_q == '1));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hold && !force_ones && !force_zero) |=> $stable(stage_q));

  a_r6_low_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    (skip_low && !force_ones && !force_zero) |=>
      (stage_q[SKIP-1:0] == $past(stage_q[SKIP-1:0])));

  a_r8_section_step: assert property (@(posedge clk) disable iff (!rst_int_n)
    (split && !hold) |=>
      (stage_q[SECTION-1:0] == SECTION'($past(stage_q[SECTION-1:0]) + SECTION'(1))));

  a_r9_direct: assert property (@(posedge clk) disable iff (!rst_int_n)
    !oneshot_en |-> (tap_out == stage_q[BASE + int'(tap_sel)]));

  a_r10_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    (oneshot_en && $rose(tap_bit)) ##1 oneshot_en |-> tap_out);

endmodule

bind prog_tap_timer ptt_checker #(
  .STAGES (STAGES),
  .SECTION(SECTION),
  .SKIP   (SKIP),
  .SEL_W  (SEL_W)
) chk_i (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .hold      (hold),
  .skip_low  (skip_low),
  .force_ones(force_ones),
  .force_zero(force_zero),
  .tap_sel   (tap_sel),
  .oneshot_en(oneshot_en),
  .stage_q   (stage_q),
  .tap_bit   (tap_bit),
  .tap_out   (tap_out)
);

// File: tb/prog_tap_timer_tb.sv
module prog_tap_timer_tb_top;

  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hold, skip_low, force_ones, force_zero, oneshot_en;
  logic [3:0] tap_sel;
  logic [7:0] pulse_width;
  logic       tap_out;

  int    checks   = 0;
  int    failures = 0;
  bit    finished = 0;
  item_t sb_q[$];

  logic [23:0] ref_cnt;
  logic        ref_prev;
  int          ref_left;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_tap_timer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .skip_low   (skip_low),
    .force_ones (force_ones),
    .force_zero (force_zero),
    .tap_sel    (tap_sel),
    .oneshot_en (oneshot_en),
    .pulse_width(pulse_width),
    .tap_out    (tap_out)
  );

  // Driver: applies one cycle of stimulus, advances the reference, queues the expectation.
  task automatic step(input logic h, input logic sk, input logic on, input logic ze,
                      input logic [3:0] s, input logic oe, input logic [7:0] w,
                      input string tag);
    logic old_tap;
    logic [7:0] sec;
    @(negedge clk);
    hold = h; skip_low = sk; force_ones = on; force_zero = ze;
    tap_sel = s; oneshot_en = oe; pulse_width = w;
    @(posedge clk);
    old_tap = ref_cnt[8 + int'(s)];
    if (old_tap && !ref_prev) ref_left = (w == 0) ? 1 : int'(w);
    else if (ref_left > 0)    ref_left = ref_left - 1;
    ref_prev = old_tap;
    if (sk && on && ze) begin
      if (!h) begin
        for (int k = 0; k < 3; k++) begin
          sec = ref_cnt[k*8 +: 8] + 8'd1;
          ref_cnt[k*8 +: 8] = sec;
        end
      end
    end else if (ze)      ref_cnt = '0;
    else if (on)          ref_cnt = '1;
    else if (!h) begin
      if (sk) ref_cnt[23:8] = ref_cnt[23:8] + 16'd1;
      else    ref_cnt       = ref_cnt + 24'd1;
    end
    #1;
    sb_q.push_back('{exp: (oe ? (ref_left != 0) : ref_cnt[8 + int'(s)]), tag: tag});
  endtask

  // Monitor: compares every queued expectation against the port.
  always @(posedge clk) begin
    item_t it;
    #2;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      checks++;
      if (tap_out !== it.exp) begin
        failures++;
        $display("FAIL %s: tap_out actual=%0b expected=%0b at %0t", it.tag, tap_out, it.exp, $time);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hold = 1'b1; skip_low = 1'b0; force_ones = 1'b0; force_zero = 1'b0;
    tap_sel = 4'd0; oneshot_en = 1'b0; pulse_width = 8'd1;
    ref_cnt = '0; ref_prev = 1'b0; ref_left = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    checks++;   // R1 reset state
    if (tap_out !== 1'b0) begin
      failures++;
      $display("FAIL R1: tap_out actual=%0b expected=0", tap_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R9: plain counting, carry into stage 9 after 256 cycles
    for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 4'd0, 0, 8'd1, "R2");
    // R7: sweep the tap code
    for (int i = 0; i < 48; i++) step(0, 0, 0, 0, 4'(i % 16), 0, 8'd1, "R7");

    // R4 fill, R5 hold, R2 wrap
    step(1, 0, 1, 0, 4'd15, 0, 8'd1, "R4");
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 4'(i), 0, 8'd1, "R5");
    step(0, 0, 0, 0, 4'd15, 0, 8'd1, "R2");
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 4'(i), 0, 8'd1, "R2");

    // R3: clear beats fill, and acts under hold
    step(0, 0, 1, 0, 4'd3, 0, 8'd1, "R4");
    step(0, 0, 1, 1, 4'd3, 0, 8'd1, "R3");
    step(0, 0, 1, 0, 4'd9, 0, 8'd1, "R4");
    step(1, 0, 0, 1, 4'd9, 0, 8'd1, "R3");

    // R6: preload low byte, skip, then resume and watch the carry
    for (int i = 0; i < 200; i++) step(0, 0, 0, 0, 4'd0, 0, 8'd1, "R2");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 4'd0, 0, 8'd1, "R6");
    for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 4'(i % 4), 0, 8'd1, "R7");
    step(1, 1, 0, 0, 4'd1, 0, 8'd1, "R5");
    for (int i = 0; i < 70; i++) step(0, 0, 0, 0, 4'd0, 0, 8'd1, "R6");

    // R8: split mode from a cleared chain
    step(0, 0, 0, 1, 4'd0, 0, 8'd1, "R3");
    for (int i = 0; i < 300; i++)
      step((i % 37) == 5, 1, 1, 1, 4'((i / 20) % 16), 0, 8'd1, "R8");
    step(0, 0, 0, 1, 4'd0, 0, 8'd1, "R3");

    // R10: one-shot with skip, tap at stage 10 rising every 4 clocks
    for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 4'd1, 1, 8'd2, "R10");
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 4'd1, 1, 8'd0, "R10");
    // R11: width longer than the edge spacing keeps retriggering
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 4'd0, 1, 8'd5, "R11");
    for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 4'd2, 1, 8'd5, "R11");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 4'd2, 0, 8'd5, "R9");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R9: queue actual=%0d expected=0", sb_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule